// File: doc/BRIEF.md
# SPI Master with Free-Running Bit Clock

This block is the serial engine of an SPI master. It moves one 8-bit frame out on MOSI, MSB first, and takes one frame in from MISO at the same time. The bit clock comes from a counter that divides the system clock and runs the whole time the block is both enabled and set as master. A write does not restart that counter. A write only arms a frame, and the frame waits for the next bit boundary of the running counter. The delay from a write to the first bit therefore depends on the divider phase at the moment of the write and on the selected rate. It never depends on the clock phase setting.

The host sets `cpol`, `cpha` and `rate_sel` while the block is idle, then pulses `wr_en` with a byte. When the frame ends, `xfer_done` rises and `rx_data` holds the byte that came in. A write made while a frame is in progress is held in a one-byte buffer. That frame then follows the current one with no idle gap. Chip-select generation, fault detection and interrupts belong to the surrounding logic.

The engine is a four-state machine:
- `ST_IDLE`: no frame.
- `ST_WAIT`: a frame is armed and waits for a bit boundary.
- `ST_LEAD`: the first half of a bit.
- `ST_TRAIL`: the second half of a bit.

Its transitions are:
- IDLE→WAIT on an accepted write.
- WAIT→LEAD on a bit boundary.
- LEAD→TRAIL on a half-bit tick.
- TRAIL→LEAD on a half-bit tick, either for the next bit or for a chained frame.
- TRAIL→IDLE on the half-bit tick that ends the eighth bit when nothing is buffered.
- Any state→IDLE while the block is not running.

Top module: `spi_freerun_master`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: `sck` equal to `cpol`, `mosi` 0, `xfer_done` 0 and `rx_data` 0.
- R2: The rate code sets the bit period D in system clocks: code 0 gives D = 2, code 1 gives D = 8, code 2 gives D = 32 and code 3 gives D = 128. Successive SCK transitions are exactly D/2 clocks apart.
- R3: The divider count is cleared whenever `spi_en` and `master_sel` are not both 1. While both are 1, the count rises by one each clock. A bit boundary is a clock edge at which the count before the edge, taken mod D, equals D-1. The first bit of a frame begins at the first bit boundary strictly after the edge that samples the write.
- R4: With `cpha` = 0, SCK holds the `cpol` level for the first D/2 clocks of the first bit. Its first transition therefore comes D/2 clocks after that bit begins.
- R5: With `cpha` = 1, SCK moves from the `cpol` level to the active level at the very edge where the first bit begins. MOSI carries the first data bit from that edge onward.
- R6: MOSI sends the written byte MSB first. Each bit is stable across the SCK transition that falls in the middle of its bit period. That is the first transition of the bit when `cpha` = 0 and the second when `cpha` = 1.
- R7: MISO is sampled at that same mid-bit transition, and the first sample becomes bit 7 of the received byte.
- R8: A frame has exactly 16 SCK transitions. After the eighth bit, SCK rests at the `cpol` level, `rx_data` shows the received byte and `xfer_done` is 1.
- R9: An accepted write clears `xfer_done`, and this is visible on the clock after the write is sampled.
- R10: A write made during a frame is held. The held byte goes out as the next frame with SCK spacing D/2 across the frame boundary. If several writes are held, the last one is sent. `xfer_done` is set again at the end of each frame.
- R11: A write while `spi_en` or `master_sel` is 0 has no effect: SCK does not move, and `xfer_done` and `rx_data` keep their values.
- R12: MOSI is 0 whenever no frame is in its bit phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_en | input | 1 | Block enable |
| master_sel | input | 1 | Master mode; the divider runs only when this and `spi_en` are 1 |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase: 0 = sample at the first edge of each bit, 1 = at the second |
| rate_sel | input | 2 | Divider code (D = 2, 8, 32, 128) |
| wr_en | input | 1 | One-clock write strobe for a transmit byte |
| wr_data | input | DATA_W | Byte to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rx_data | output | DATA_W | Last complete received byte |
| xfer_done | output | 1 | Frame-complete flag |

## Verification
Suppose the divider phase is wrong, or the machine leaves WAIT on a half-bit tick instead of a bit boundary. The first SCK transition then lands at a cycle that differs from the one predicted from the clocks counted since enable. The sweep over all rate codes, modes and write phases shows this on the first frame. Suppose instead a fault in the bit counter or the shift registers. That shows at the end of the same frame as a transition count other than 16, a wrong serial byte, or a wrong `rx_data`. A buffer that drops or reorders bytes shows as an uneven SCK spacing or a wrong second byte in the chained test. A block that accepts writes while disabled shows as SCK transitions during the idle window.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;

    localparam int RATE_W    = 2;
    localparam int DIV_CNT_W = 2 * (1 << RATE_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_TRAIL
    } spi_state_e;

    // Low bits of the divider that span one bit period: D = 2^(2*sel+1)
    function automatic logic [DIV_CNT_W-1:0] period_mask(input logic [RATE_W-1:0] sel);
        return DIV_CNT_W'((1 << (2 * int'(sel) + 1)) - 1);
    endfunction

endpackage

// File: rtl/spi_fr_baud.sv
module spi_fr_baud
    import spi_fr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              half_tick,
    output logic              bit_tick
);

    logic [DIV_CNT_W-1:0] cnt;
    logic [DIV_CNT_W-1:0] full_mask;
    logic [DIV_CNT_W-1:0] half_mask;

    always_comb begin
        full_mask = period_mask(rate_sel);
        half_mask = full_mask >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign half_tick = run && ((cnt & half_mask) == half_mask);
    assign bit_tick  = run && ((cnt & full_mask) == full_mask);

    // R3
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run)) |-> cnt == $past(cnt) + 1'b1);

    // R3
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run)) |-> cnt == '0);

endmodule

// File: rtl/spi_fr_engine.sv
module spi_fr_engine
    import spi_fr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              half_tick,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);

    localparam int IDX_W = $clog2(DATA_W);

    spi_state_e        state, state_nx;
    logic [DATA_W-1:0] tx_sh, rx_sh, buf_data, rx_q;
    logic              buf_full, done_q;
    logic [IDX_W-1:0]  bit_idx;
    logic              wr_ok, busy, last_bit, frame_end, chain;

    assign wr_ok     = wr_en && run;
    assign busy      = (state == ST_LEAD) || (state == ST_TRAIL);
    assign last_bit  = bit_idx == IDX_W'(DATA_W - 1);
    assign frame_end = (state == ST_TRAIL) && half_tick && last_bit;
    assign chain     = buf_full || wr_ok;

    always_comb begin
        state_nx = state;
        if (!run) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (wr_ok)     state_nx = ST_WAIT;
                ST_WAIT:  if (bit_tick)  state_nx = ST_LEAD;
                ST_LEAD:  if (half_tick) state_nx = ST_TRAIL;
                ST_TRAIL: if (half_tick) state_nx = (last_bit && !chain) ? ST_IDLE : ST_LEAD;
                default:                 state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            buf_data <= '0;
            rx_q     <= '0;
            buf_full <= 1'b0;
            done_q   <= 1'b0;
            bit_idx  <= '0;
        end else if (!run) begin
            buf_full <= 1'b0;
            bit_idx  <= '0;
        end else begin
            if (wr_ok) done_q <= 1'b0;
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                    bit_idx <= '0;
                    if (wr_ok) tx_sh <= wr_data;
                end
                ST_LEAD: begin
                    if (wr_ok) begin
                        buf_data <= wr_data;
                        buf_full <= 1'b1;
                    end
                    if (half_tick) rx_sh <= {rx_sh[DATA_W-2:0], miso};
                end
                ST_TRAIL: begin
                    if (wr_ok) begin
                        buf_data <= wr_data;
                        buf_full <= 1'b1;
                    end
                    if (half_tick) begin
                        if (last_bit) begin
                            rx_q    <= rx_sh;
                            done_q  <= !wr_ok;
                            bit_idx <= '0;
                            if (chain) begin
                                tx_sh    <= wr_ok ? wr_data : buf_data;
                                buf_full <= 1'b0;
                            end
                        end else begin
                            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sck  = cpol ^ ((state == ST_LEAD && cpha) || (state == ST_TRAIL && !cpha));
        mosi = busy ? tx_sh[DATA_W-1] : 1'b0;
    end

    assign rx_data = rx_q;
    assign done    = done_q;

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state) == ST_TRAIL && $past(half_tick)));

    // R9
    wr_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !frame_end) |=> !done_q);

    // R3
    wait_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && run && !bit_tick) |=> state == ST_WAIT);

    // R2
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run && !half_tick) |=> ($stable(state) && $stable(tx_sh)));

    // R10
    idle_no_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !buf_full);

    // R11
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state == ST_IDLE);

endmodule

// File: rtl/spi_freerun_master.sv
module spi_freerun_master
    import spi_fr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_en,
    input  logic              master_sel,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              xfer_done
);

    logic run, half_tick, bit_tick;

    assign run = spi_en && master_sel;

    spi_fr_baud baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rate_sel  (rate_sel),
        .half_tick (half_tick),
        .bit_tick  (bit_tick)
    );

    spi_fr_engine #(.DATA_W(DATA_W)) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpol      (cpol),
        .cpha      (cpha),
        .half_tick (half_tick),
        .bit_tick  (bit_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .rx_data   (rx_data),
        .done      (xfer_done)
    );

endmodule

// File: tb/spi_freerun_master_tb.sv
module spi_freerun_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, spi_en, master_sel, cpol, cpha, wr_en;
    logic       miso = 1'b0;
    logic [1:0] rate_sel;
    logic [7:0] wr_data;
    logic       sck, mosi, xfer_done;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    spi_freerun_master #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .master_sel(master_sel),
        .cpol(cpol), .cpha(cpha), .rate_sel(rate_sel), .wr_en(wr_en),
        .wr_data(wr_data), .miso(miso), .sck(sck), .mosi(mosi),
        .rx_data(rx_data), .xfer_done(xfer_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ecnt    = 0;

    // clocks since the divider was last allowed to run (R3 definition)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || !(spi_en && master_sel)) ecnt <= 0;
        else                                   ecnt <= ecnt + 1;
    end

    // bus monitor and slave model
    int          nedge = 0;
    int          base  = 0;
    logic        sck_prev = 1'b0;
    int          edge_t [64];
    logic [63:0] mosi_sr = '0;
    logic [31:0] slave_word = '0;

    always @(negedge clk) begin
        int k, idx;
        if (sck !== sck_prev) begin
            edge_t[nedge % 64] = cyc;
            nedge++;
            sck_prev = sck;
            k = nedge - base;
            if (cpha ? (k > 0 && k % 2 == 0) : (k % 2 == 1))
                mosi_sr = {mosi_sr[62:0], mosi};
        end
        k   = nedge - base;
        idx = cpha ? ((k == 0) ? 0 : (k - 1) / 2) : k / 2;
        miso = (idx < 32) ? slave_word[31 - idx] : 1'b0;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            $display("FAIL R8 watchdog expired act=%0d exp=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic frame(input int r, input logic pol, input logic pha,
                         input logic [7:0] tx, input logic [7:0] sl, input int pre);
        int d, c, p, j, lim, bad;
        d = 2 << (2 * r);
        rate_sel = 2'(r); cpol = pol; cpha = pha;
        repeat (pre + 2) tick();
        base = nedge;
        slave_word = {sl, 24'h0};
        c = ecnt; p = cyc + 1;
        wr_en = 1'b1; wr_data = tx;
        tick();
        wr_en = 1'b0;
        chk("R9 write clears done", xfer_done, 0);
        lim = 0;
        while (!xfer_done && lim < 20 * d + 50) begin tick(); lim++; end
        chk("R8 done set", xfer_done, 1);
        chk("R8 transition count", nedge - base, 16);
        chk("R8 sck idle level", sck, pol);
        chk("R6 mosi byte", mosi_sr[7:0], tx);
        chk("R7 received byte", rx_data, sl);
        chk("R12 mosi idle", mosi, 0);
        j = d - ((c + 1) % d);
        if (pha) chk("R3 R5 first edge cycle", edge_t[base % 64], p + j);
        else     chk("R3 R4 first edge cycle", edge_t[base % 64], p + j + d / 2);
        bad = 0;
        for (int i = 1; i < 16; i++)
            if (edge_t[(base + i) % 64] - edge_t[(base + i - 1) % 64] != d / 2) bad++;
        chk("R2 edge spacing", bad, 0);
    endtask

    task automatic chained(input logic pol, input logic pha);
        int lim, bad;
        rate_sel = 2'd1; cpol = pol; cpha = pha;
        repeat (3) tick();
        base = nedge;
        slave_word = {8'h3C, 8'hA5, 16'h0};
        wr_en = 1'b1; wr_data = 8'h96;
        tick();
        wr_en = 1'b0;
        repeat (12) tick();
        wr_en = 1'b1; wr_data = 8'h11;
        tick();
        wr_data = 8'h4E;
        tick();
        wr_en = 1'b0;
        lim = 0;
        while (!xfer_done && lim < 400) begin tick(); lim++; end
        chk("R10 first frame done", xfer_done, 1);
        chk("R7 R10 first received byte", rx_data, 8'h3C);
        lim = 0;
        while ((nedge - base) < 32 && lim < 400) begin tick(); lim++; end
        repeat (10) tick();
        chk("R10 chained transition count", nedge - base, 32);
        chk("R10 chained bytes last write wins", mosi_sr[15:0], 16'h964E);
        chk("R10 second received byte", rx_data, 8'hA5);
        chk("R10 done after chain", xfer_done, 1);
        bad = 0;
        for (int i = 1; i < 32; i++)
            if (edge_t[(base + i) % 64] - edge_t[(base + i - 1) % 64] != 4) bad++;
        chk("R10 no gap between frames", bad, 0);
    endtask

    task automatic ignored(input logic en, input logic ms);
        logic [7:0] rx_keep;
        logic       done_keep;
        rx_keep = rx_data; done_keep = xfer_done;
        spi_en = en; master_sel = ms;
        repeat (3) tick();
        base = nedge;
        wr_en = 1'b1; wr_data = 8'hFF;
        tick();
        wr_en = 1'b0;
        repeat (300) tick();
        chk("R11 no sck activity", nedge - base, 0);
        chk("R11 sck at idle", sck, cpol);
        chk("R11 done kept", xfer_done, done_keep);
        chk("R11 rx kept", rx_data, rx_keep);
        spi_en = 1'b1; master_sel = 1'b1;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; spi_en = 1'b0; master_sel = 1'b0;
        cpol = 1'b0; cpha = 1'b0; rate_sel = 2'd0;
        wr_en = 1'b0; wr_data = 8'h00;
        repeat (3) tick();
        chk("R1 sck in reset", sck, 0);
        chk("R1 done in reset", xfer_done, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 sck after reset", sck, 0);
        chk("R1 mosi after reset", mosi, 0);
        chk("R1 done after reset", xfer_done, 0);
        chk("R1 rx after reset", rx_data, 0);
        spi_en = 1'b1; master_sel = 1'b1;
        tick();

        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 4; m++)
                for (int k = 0; k < 2; k++)
                    frame(r, m[1], m[0],
                          8'(8'h5A ^ (r * 37 + m * 11 + k * 90)),
                          8'(8'hC3 ^ (r * 19 + m * 53 + k * 7)),
                          m + 3 * r + k);

        for (int ph = 0; ph < 8; ph++)
            frame(1, 1'b0, 1'b1, 8'(8'h81 + ph * 17), 8'(8'h7E - ph * 9), ph);

        chained(1'b0, 1'b0);
        chained(1'b1, 1'b1);

        ignored(1'b0, 1'b1);
        ignored(1'b1, 1'b0);

        frame(2, 1'b1, 1'b0, 8'hE7, 8'h18, 5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule